// File: doc/BRIEF.md
# Aliased Set/Clear Interrupt Status Register

This block holds one 64-bit miscellaneous control and status word on a word-addressed register bus. Three neighbouring write addresses update the same stored value: a direct load, a mask alias and an OR alias. Software can therefore set or clear individual flags without a read-modify-write sequence. Bits are numbered MSB-0, so "bit 0" is bit 63 of the bus word. Only the top 19 bits (MSB-0 bits 0 to 18) are implemented. Accesses are full 64-bit words in big-endian order.

Stored bit 0 drives a level interrupt toward an interrupt controller. An internal message strobe sets the interrupt bit and a message-pending bit (MSB-0 bit 3) in one update. The parameter `VARIANT` picks the address set and the meaning of the second alias:
- With 0, the register is at 0x4020, a bitwise AND alias at 0x4021 and the OR alias at 0x4022.
- With 1, the register is at 0x6080, a clear alias at 0x6081 and the OR alias at 0x6082.

Top module: `misc_status_reg`

## Requirements
- R1: A write to the base address loads the write data, masked to the kept bits, into the register. A read at the base address returns the stored value combinationally.
- R2: A write to the OR alias (base+1 after the mask alias, i.e. base+2) ORs the write data into the register.
- R3: With VARIANT 0, a write to base+1 ANDs the write data into the register.
- R4: With VARIANT 1, a write to base+1 sets the register to zero whatever the write data.
- R5: After every update only LSB-0 bits 63..45 (MSB-0 bits 0..18) can be nonzero. All other bits read as zero.
- R6: `irq_out` is high exactly when stored LSB-0 bit 63 (MSB-0 bit 0) is set.
- R7: A pulse on `raise_msg` sets LSB-0 bits 63 and 60 (MSB-0 bits 0 and 3) in one clock, leaving other bits unchanged.
- R8: When a bus write and `raise_msg` occur in the same cycle, the write is applied first and the raise bits are then ORed into the result.
- R9: Reads at any address other than the base return zero, including the two alias addresses. Writes to addresses outside the three decoded ones leave the register unchanged.
- R10: Reset clears the register to zero and deasserts `irq_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus access request this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data, MSB-0 bit 0 at bit 63 |
| bus_rdata | output | DATA_W | Read data, combinational |
| raise_msg | input | 1 | Internal strobe: set interrupt and message bits |
| irq_out | output | 1 | Level interrupt output |

## Verification
The assertions assume that `bus_valid`, `bus_write` and `bus_addr` are known during every clock after reset. They also assume that a write and a raise strobe are treated as one combined update, never as two ordered cycles. The stimulus changes all inputs on the falling edge and holds them through the rising edge. It mixes in random simultaneous write-and-raise cycles, so that the combined-update case is exercised. Random addresses cover the three decoded words, their neighbours and the base address of the other variant.

// File: rtl/misc_status_reg.sv
module misc_status_reg #(
  parameter int VARIANT   = 0,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 64,
  parameter int KEEP_BITS = 19,
  parameter int IRQ_BIT   = 0,
  parameter int MSG_BIT   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              raise_msg,
  output logic              irq_out
);
  localparam logic [ADDR_W-1:0] BASE     = (VARIANT == 0) ? ADDR_W'(16'h4020) : ADDR_W'(16'h6080);
  localparam logic [ADDR_W-1:0] MASK_ADR = BASE + ADDR_W'(1);
  localparam logic [ADDR_W-1:0] OR_ADR   = BASE + ADDR_W'(2);
  localparam int IRQ_POS = DATA_W - 1 - IRQ_BIT;
  localparam int MSG_POS = DATA_W - 1 - MSG_BIT;
  localparam logic [DATA_W-1:0] KEEP_MASK  = ~({DATA_W{1'b1}} >> KEEP_BITS);
  localparam logic [DATA_W-1:0] RAISE_BITS = (DATA_W'(1) << IRQ_POS) | (DATA_W'(1) << MSG_POS);

  logic [DATA_W-1:0] stored, wr_val, nxt;
  logic wr;

  assign wr = bus_valid && bus_write;

  always_comb begin
    wr_val = stored;
    if (wr) begin
      if (bus_addr == BASE)          wr_val = bus_wdata;
      else if (bus_addr == OR_ADR)   wr_val = stored | bus_wdata;
      else if (bus_addr == MASK_ADR) wr_val = (VARIANT == 0) ? (stored & bus_wdata) : '0;
    end
    nxt = (raise_msg ? (wr_val | RAISE_BITS) : wr_val) & KEEP_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stored <= '0;
    else        stored <= nxt;
  end

  assign bus_rdata = (bus_valid && !bus_write && bus_addr == BASE) ? stored : '0;
  assign irq_out   = stored[IRQ_POS];

  a_r5_kept_bits_only: assert property (@(posedge clk) disable iff (!rst_n)
    (stored & ~KEEP_MASK) == '0);

  a_r7_raise_sets_bits: assert property (@(posedge clk) disable iff (!rst_n)
    raise_msg |=> irq_out && stored[MSG_POS]);

  a_r2_or_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == OR_ADR && !raise_msg) |=> stored == ($past(stored | bus_wdata) & KEEP_MASK));

  a_r9_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr != BASE && bus_addr != MASK_ADR && bus_addr != OR_ADR && !raise_msg) |=> $stable(stored));

  a_r6_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> $past(raise_msg) || $past(wr));

  generate
    if (VARIANT != 0) begin : g_clear
      a_r4_clear_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == MASK_ADR && !raise_msg) |=> stored == '0);
    end else begin : g_and
      a_r3_and_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == MASK_ADR && !raise_msg) |=> stored == ($past(stored & bus_wdata) & KEEP_MASK));
    end
  endgenerate
endmodule

// File: tb/misc_status_reg_tb.sv
module misc_status_reg_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] KEEP  = 64'hFFFF_E000_0000_0000;
  localparam logic [63:0] RAISE = 64'h9000_0000_0000_0000;

  logic clk = 0, rst_n = 0;
  logic va, wa, vb, wb, raise;
  logic [15:0] adra, adrb;
  logic [63:0] wdata, rda, rdb;
  logic irqa, irqb;
  logic [63:0] ma, mb;
  int compared = 0, mismatched = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  misc_status_reg #(.VARIANT(0)) u_dut (.clk(clk), .rst_n(rst_n), .bus_valid(va), .bus_write(wa),
    .bus_addr(adra), .bus_wdata(wdata), .bus_rdata(rda), .raise_msg(raise), .irq_out(irqa));
  misc_status_reg #(.VARIANT(1)) u_dut_clr (.clk(clk), .rst_n(rst_n), .bus_valid(vb), .bus_write(wb),
    .bus_addr(adrb), .bus_wdata(wdata), .bus_rdata(rdb), .raise_msg(raise), .irq_out(irqb));

  function automatic logic [15:0] base_of(int v);
    return (v == 0) ? 16'h4020 : 16'h6080;
  endfunction

  function automatic logic [63:0] model(logic [63:0] s, int v, logic [15:0] a, logic w,
                                        logic [63:0] d, logic r);
    logic [63:0] n = s;
    logic [15:0] b = base_of(v);
    if (w) begin
      if (a == b)           n = d;
      else if (a == b + 2)  n = s | d;
      else if (a == b + 1)  n = (v == 0) ? (s & d) : 64'd0;
    end
    if (r) n = n | RAISE;
    return n & KEEP;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic verify(input string tag);
    va = 1; wa = 0; adra = 16'h4020; vb = 1; wb = 0; adrb = 16'h6080;
    #1;
    check(rda === ma, {tag, " R1 read A"}, rda, ma);
    check(rdb === mb, {tag, " R1 read B"}, rdb, mb);
    check((rda & ~KEEP) == 0 && (rdb & ~KEEP) == 0, {tag, " R5 unkept bits"}, rda | rdb, 64'd0);
    check(irqa === ma[63] && irqb === mb[63], {tag, " R6 irq level"}, {62'd0, irqa, irqb}, {62'd0, ma[63], mb[63]});
    adra = 16'h4021; adrb = 16'h6082;
    #1;
    check(rda === 0 && rdb === 0, {tag, " R9 alias read zero"}, rda | rdb, 64'd0);
    va = 0; vb = 0;
  endtask

  task automatic op(input logic [15:0] offa, input logic [15:0] offb, input logic w,
                    input logic [63:0] d, input logic r, input string tag);
    @(negedge clk);
    va = w; wa = w; vb = w; wb = w; adra = offa; adrb = offb; wdata = d; raise = r;
    ma = model(ma, 0, offa, w, d, r);
    mb = model(mb, 1, offb, w, d, r);
    @(negedge clk);
    va = 0; vb = 0; wa = 0; wb = 0; raise = 0;
    verify(tag);
  endtask

  function automatic logic [15:0] pick(int v, int sel);
    logic [15:0] b = base_of(v);
    case (sel)
      0: return b;
      1: return b + 1;
      2: return b + 2;
      3: return base_of(1 - v);
      4: return b - 1;
      5: return b + 3;
      default: return b;
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    va = 0; wa = 0; vb = 0; wb = 0; raise = 0; adra = 0; adrb = 0; wdata = 0;
    ma = 0; mb = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    verify("R10 reset");
    // R1 direct write of all ones keeps only the top 19 bits (R5)
    op(16'h4020, 16'h6080, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R1 direct all ones");
    check(ma === 64'hFFFF_E000_0000_0000, "R5 model mask", ma, 64'hFFFF_E000_0000_0000);
    // R3 AND alias / R4 clear alias with data all ones
    op(16'h4021, 16'h6081, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R3 R4 mask alias ones");
    op(16'h4021, 16'h6080, 1, 64'hA5A5_0000_0000_0000, 0, "R3 and pattern");
    // R2 OR alias
    op(16'h4022, 16'h6082, 1, 64'h0F0F_F000_0000_1234, 0, "R2 or alias");
    // R9 unmapped writes
    op(16'h6080, 16'h4020, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R9 other base write");
    op(16'h4023, 16'h607F, 1, 64'h0, 0, "R9 neighbour write");
    // clear then R7 raise alone
    op(16'h4020, 16'h6081, 1, 64'h0, 0, "R4 clear");
    op(16'h0, 16'h0, 0, 64'h0, 1, "R7 raise alone");
    check(irqa === 1 && rda === 64'h0, "R7 irq after raise", {63'd0, irqa}, 64'd1);
    // R8 simultaneous write of zero and raise
    op(16'h4020, 16'h6081, 1, 64'h0000_2000_0000_0000, 1, "R8 write with raise");
    op(16'h4021, 16'h6080, 1, 64'h0, 1, "R8 and-zero with raise");
    op(16'h4020, 16'h6080, 1, 64'h0, 0, "R6 irq drop");
    check(irqa === 0 && irqb === 0, "R6 irq low", {62'd0, irqa, irqb}, 64'd0);
    for (int i = 0; i < 400; i++) begin
      int sa = $urandom % 8;
      int sb = $urandom % 8;
      logic [63:0] d = {$urandom, $urandom};
      op(pick(0, sa), pick(1, sb), ($urandom % 4) != 0, d, ($urandom % 5) == 0, "random");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule